// File: doc/BRIEF.md
# Single-Word Tracked RAM Model

This block stands in for a synchronous one-read, one-write RAM inside a formal proof environment. It holds real storage for exactly one location, chosen by a parameter. A proof engine then carries one data word of state instead of the full array. The proofs stay valid for any property whose fan-in touches only that location. Reads of every other location return whatever the environment drives on a free-data input. The tool treats that input as unconstrained, so those reads behave as arbitrary memory contents.

The interface matches the RAM it replaces: a write port with enable, address and data, and a read port with enable and address. Read data is registered and appears one cycle after the read. By default the model represents 128 words of 64 bits and tracks location 100, which reduces 8192 state bits to 64. When the read port and the write port address the tracked location in the same cycle, the read returns the value held before the write.

Top module: `trk_word_ram`

## Requirements
- R1: After reset is released, `rd_data_o` is zero, and a read of the tracked address issued before any write to it returns zero.
- R2: A write with `wr_en_i`=1 to address `TRACK_ADDR` (default 100) stores `wr_data_i`. A read of that address issued in the following cycle or later returns it. The read value appears on `rd_data_o` one clock after the read cycle, and `free_data_i` has no influence on it.
- R3: A read with `rd_en_i`=1 of any address other than `TRACK_ADDR` puts on `rd_data_o`, one clock later, the value that `free_data_i` carried in the read cycle.
- R4: When a read and a write both address `TRACK_ADDR` in the same cycle, the read returns the word stored before that write. The new word is returned from the next cycle on.
- R5: A write to any address other than `TRACK_ADDR` leaves the tracked word unchanged. A later read of the written untracked address still returns `free_data_i`, not the written data.
- R6: In a cycle with `rd_en_i`=0, `rd_data_o` keeps its previous value on the next clock.
- R7: While `wr_en_i`=0, the tracked word does not change, whatever `wr_addr_i` and `wr_data_i` carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write enable |
| wr_addr_i | input | $clog2(DEPTH) | Write address |
| wr_data_i | input | WIDTH | Write data |
| rd_en_i | input | 1 | Read enable |
| rd_addr_i | input | $clog2(DEPTH) | Read address |
| free_data_i | input | WIDTH | Unconstrained data returned for untracked reads |
| rd_data_o | output | WIDTH | Registered read data |

## Verification
Every result of this block is due exactly one rising edge after the cycle that caused it. A read issued in cycle N shows its data after edge N+1. A write in cycle N changes what reads issued in cycle N+1 return. A free-data value counts only if it is present in the read cycle itself.

The bench drives each cycle's inputs on the falling edge. Before the rising edge, it predicts the output from a behavioural model that holds the tracked word and the last output. It then compares `rd_data_o` shortly after that rising edge, so every cycle's prediction is checked against the edge that produced it. Same-cycle read and write of the tracked address is predicted from the model's state before the edge, which checks the old-value ordering.

// File: rtl/trk_word_ram_pkg.sv
package trk_word_ram_pkg;

   // Source selected for the read data register
   typedef enum logic {
      RD_SRC_FREE  = 1'b0,
      RD_SRC_TRACK = 1'b1
   } rd_src_e;

   // Port indices into the address comparator
   localparam int unsigned PORT_WR = 0;
   localparam int unsigned PORT_RD = 1;
   localparam int unsigned NUM_PORTS = 2;

   function automatic int unsigned addr_bits(input int unsigned depth);
      return (depth > 1) ? $clog2(depth) : 1;
   endfunction

endpackage

// File: rtl/trk_addr_match.sv
module trk_addr_match #(
   parameter int unsigned AW         = 7,
   parameter int unsigned NPORT      = 2,
   parameter int unsigned TRACK_ADDR = 100
) (
   input  logic [NPORT*AW-1:0] addr_i,
   output logic [NPORT-1:0]    hit_o
);

   localparam logic [AW-1:0] TRK = AW'(TRACK_ADDR);

   if (AW == 0) begin : g_bad_aw
      $error("trk_addr_match: AW must be non-zero");
   end

   for (genvar p = 0; p < NPORT; p++) begin : g_port
      assign hit_o[p] = (addr_i[p*AW +: AW] == TRK);
   end

endmodule

// File: rtl/trk_word_store.sv
module trk_word_store #(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic             wr_hit_i,
   input  logic [WIDTH-1:0] wr_data_i,
   output logic [WIDTH-1:0] word_o
);

   logic             upd;
   logic [WIDTH-1:0] word_q;

   assign upd = wr_en_i & wr_hit_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         word_q <= '0;
      end else if (upd) begin
         word_q <= wr_data_i;
      end
   end

   assign word_o = word_q;

   AST_UNTRACKED_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !wr_hit_i) |=> $stable(word_o)); // R5
   AST_NO_WRITE_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!wr_en_i) |=> $stable(word_o)); // R7
   AST_TRACKED_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_hit_i) |=> (word_o == $past(wr_data_i))); // R2

endmodule

// File: rtl/trk_read_port.sv
module trk_read_port
   import trk_word_ram_pkg::*;
#(
   parameter int unsigned WIDTH = 64
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rd_en_i,
   input  rd_src_e          src_i,
   input  logic [WIDTH-1:0] track_word_i,
   input  logic [WIDTH-1:0] free_data_i,
   output logic [WIDTH-1:0] rd_data_o
);

   logic [WIDTH-1:0] sel_d;
   logic [WIDTH-1:0] rd_q;

   always_comb begin
      unique case (src_i)
         RD_SRC_TRACK: sel_d = track_word_i;
         default:      sel_d = free_data_i;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         rd_q <= '0;
      end else if (rd_en_i) begin
         rd_q <= sel_d;
      end
   end

   assign rd_data_o = rd_q;

   AST_FREE_READ_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && src_i == RD_SRC_FREE) |=> (rd_data_o == $past(free_data_i))); // R3
   AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!rd_en_i) |=> $stable(rd_data_o)); // R6

endmodule

// File: rtl/trk_word_ram.sv
module trk_word_ram
   import trk_word_ram_pkg::*;
#(
   parameter int unsigned DEPTH      = 128,
   parameter int unsigned WIDTH      = 64,
   parameter int unsigned TRACK_ADDR = 100,
   localparam int unsigned AW        = addr_bits(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_en_i,
   input  logic [AW-1:0]    wr_addr_i,
   input  logic [WIDTH-1:0] wr_data_i,
   input  logic             rd_en_i,
   input  logic [AW-1:0]    rd_addr_i,
   input  logic [WIDTH-1:0] free_data_i,
   output logic [WIDTH-1:0] rd_data_o
);

   // Elaboration-time parameter checks
   if (DEPTH < 2) begin : g_bad_depth
      $error("trk_word_ram: DEPTH must be at least 2");
   end
   if (WIDTH == 0) begin : g_bad_width
      $error("trk_word_ram: WIDTH must be non-zero");
   end
   if (TRACK_ADDR >= DEPTH) begin : g_bad_track
      $error("trk_word_ram: TRACK_ADDR must lie below DEPTH");
   end

   logic [NUM_PORTS*AW-1:0] port_addr;
   logic [NUM_PORTS-1:0]    port_hit;
   logic [WIDTH-1:0]        track_word;
   rd_src_e                 rd_src;

   assign port_addr[PORT_WR*AW +: AW] = wr_addr_i;
   assign port_addr[PORT_RD*AW +: AW] = rd_addr_i;

   trk_addr_match #(
      .AW         (AW),
      .NPORT      (NUM_PORTS),
      .TRACK_ADDR (TRACK_ADDR)
   ) u_match (
      .addr_i (port_addr),
      .hit_o  (port_hit)
   );

   trk_word_store #(
      .WIDTH (WIDTH)
   ) u_store (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .wr_en_i   (wr_en_i),
      .wr_hit_i  (port_hit[PORT_WR]),
      .wr_data_i (wr_data_i),
      .word_o    (track_word)
   );

   assign rd_src = port_hit[PORT_RD] ? RD_SRC_TRACK : RD_SRC_FREE;

   trk_read_port #(
      .WIDTH (WIDTH)
   ) u_rd (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .rd_en_i      (rd_en_i),
      .src_i        (rd_src),
      .track_word_i (track_word),
      .free_data_i  (free_data_i),
      .rd_data_o    (rd_data_o)
   );

   localparam logic [AW-1:0] TRK = AW'(TRACK_ADDR);

   AST_READ_BEFORE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && rd_addr_i == TRK && wr_en_i && wr_addr_i == TRK)
      |=> (rd_data_o == $past(track_word))); // R4
   AST_WRITE_THEN_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rd_en_i && rd_addr_i == TRK && !(wr_en_i && wr_addr_i == TRK)
       && $past(wr_en_i && wr_addr_i == TRK))
      |=> (rd_data_o == $past(wr_data_i, 2))); // R2

endmodule

// File: tb/trk_word_ram_tb.sv
`timescale 1ns/1ps
module trk_word_ram_tb;

   localparam int unsigned DEPTH = 128;
   localparam int unsigned WIDTH = 64;
   localparam int unsigned TRK   = 100;
   localparam int unsigned AW    = $clog2(DEPTH);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             wr_en = 1'b0;
   logic [AW-1:0]    wr_addr = '0;
   logic [WIDTH-1:0] wr_data = '0;
   logic             rd_en = 1'b0;
   logic [AW-1:0]    rd_addr = '0;
   logic [WIDTH-1:0] free_data = '0;
   logic [WIDTH-1:0] rd_data;

   int unsigned n_cmp = 0;
   int unsigned n_bad = 0;
   bit          done = 1'b0;

   // Behavioural reference state
   logic [WIDTH-1:0] m_word = '0;
   logic [WIDTH-1:0] m_out  = '0;

   always #2.5 clk = ~clk;

   trk_word_ram #(
      .DEPTH      (DEPTH),
      .WIDTH      (WIDTH),
      .TRACK_ADDR (TRK)
   ) u_dut (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .wr_en_i     (wr_en),
      .wr_addr_i   (wr_addr),
      .wr_data_i   (wr_data),
      .rd_en_i     (rd_en),
      .rd_addr_i   (rd_addr),
      .free_data_i (free_data),
      .rd_data_o   (rd_data)
   );

   function automatic logic [WIDTH-1:0] rnd64();
      return {$urandom(), $urandom()};
   endfunction

   task automatic check(input string req, input logic [WIDTH-1:0] exp);
      n_cmp++;
      if (rd_data !== exp) begin
         n_bad++;
         $display("FAIL %s: rd_data=%h expected=%h at %0t", req, rd_data, exp, $time);
      end
   endtask

   // One clock: drive on falling edge, predict, compare just after rising edge
   task automatic step(input logic we, input logic [AW-1:0] wa, input logic [WIDTH-1:0] wd,
                       input logic re, input logic [AW-1:0] ra, input logic [WIDTH-1:0] fd,
                       input string req);
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd;
      rd_en = re; rd_addr = ra; free_data = fd;
      if (re) m_out = (ra == AW'(TRK)) ? m_word : fd;
      @(posedge clk);
      if (we && wa == AW'(TRK)) m_word = wd;
      #1;
      check(req, m_out);
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [WIDTH-1:0] d;
      repeat (3) @(posedge clk);
      #1;
      check("R1 reset output", '0);
      @(negedge clk);
      rst_n = 1'b1;
      // R1: tracked word reads zero before any write, free data ignored
      step(0, '0, '0, 1, AW'(TRK), 64'hDEAD_BEEF_0000_1111, "R1");
      // R2: write then read next cycle
      d = 64'h0123_4567_89AB_CDEF;
      step(1, AW'(TRK), d, 0, '0, rnd64(), "R2 write");
      step(0, '0, '0, 1, AW'(TRK), rnd64(), "R2 read");
      // R6: idle read holds
      step(0, '0, '0, 0, AW'(5), rnd64(), "R6 hold");
      // R3: untracked read echoes free data
      step(0, '0, '0, 1, AW'(0), 64'hAAAA_5555_AAAA_5555, "R3 addr0");
      step(0, '0, '0, 1, AW'(DEPTH-1), 64'h1234_0000_FFFF_9999, "R3 top");
      step(0, '0, '0, 1, AW'(TRK+1), 64'h0F0F_0F0F_0F0F_0F0F, "R3 neighbour");
      // R4: same-cycle read/write returns old then new
      step(1, AW'(TRK), 64'hFACE_FACE_FACE_FACE, 1, AW'(TRK), rnd64(), "R4 old");
      step(0, '0, '0, 1, AW'(TRK), rnd64(), "R4 new");
      // R5: untracked write ignored, untracked read still free
      step(1, AW'(TRK-1), 64'h5555_5555_5555_5555, 0, '0, rnd64(), "R5 write");
      step(0, '0, '0, 1, AW'(TRK-1), 64'h9999_8888_7777_6666, "R5 free");
      step(0, '0, '0, 1, AW'(TRK), rnd64(), "R5 kept");
      // R7: wr_en low with tracked address ignored
      step(0, AW'(TRK), 64'h7777_7777_7777_7777, 0, '0, rnd64(), "R7 nowrite");
      step(0, '0, '0, 1, AW'(TRK), rnd64(), "R7 kept");
      // Random mix, tracked address favoured
      for (int i = 0; i < 3000; i++) begin
         logic [AW-1:0] wa, ra;
         wa = ($urandom_range(0, 2) == 0) ? AW'($urandom_range(0, DEPTH-1)) : AW'(TRK);
         ra = ($urandom_range(0, 2) == 0) ? AW'($urandom_range(0, DEPTH-1)) : AW'(TRK);
         step(1'($urandom_range(0, 1)), wa, rnd64(), 1'($urandom_range(0, 1)), ra, rnd64(),
              "R2/R3/R4/R5/R6 random");
      end
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule